// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block brings up a downstream programmable device that takes its configuration over a slave-serial link. On a start pulse it latches a start address and a byte count, pulls the device's program-request line low until the device acknowledges by lowering its init line, and then releases program-request. Once the init line goes high again it fetches the image from a byte-stream source that stands in for flash. Each fetch is a burst of up to 256 bytes. The bytes are sent out on a serial clock/data pair.

After the last bit the loader waits a programmable settling interval, then samples the init and done lines. It reports one of three outcomes: a good load, a checksum failure (init low), or a device that never raised done. Each handshake wait has its own timeout, and each timeout has its own status code. A build-time variant covers boards where the program-request pin is not wired. In that variant the loader sends nothing. It waits a long fixed interval for the device to load itself and then reports success.

Top module: `slave_serial_loader`

## Requirements
- R1: Out of reset, progB is 1, sclk is 0, fetchReq is 0, srcReady is 0, busy is 0 and finished is 0.
- R2: After a start, progB is 0 until initB is seen at 0, then returns to 1. If initB stays 1 for TIMEOUT_CYCLES, the load ends with status 3.
- R3: No fetchReq is issued before initB has returned to 1 after the program pulse. If initB stays 0 for TIMEOUT_CYCLES after release, the load ends with status 4.
- R4: Each byte goes out MSB first, one bit per sclk pulse. sdata takes the bit while sclk is 0 and holds it through the following cycle in which sclk is 1. sclk pulses only while busy with progB at 1, and the number of pulses equals eight times the byte count.
- R5: The image is requested in bursts. Each burst is a one-cycle fetchReq with fetchLen = min(256, bytes left) and fetchAddr stepping on from startAddr by the lengths already requested. A byte count of 0 issues no burst.
- R6: Between SETTLE_CYCLES and SETTLE_CYCLES+5 cycles after the last sclk pulse, the load ends. If initB is 0 at the sampling point, status is 1 (checksum failure).
- R7: With initB at 1 at the sampling point, status is 2 if doneIn is 0 and 0 if doneIn is 1.
- R8: With HAS_PROG = 0, progB stays 1 and fetchReq stays 0. A start ends with finished and status 0 between SELF_CFG_CYCLES and SELF_CFG_CYCLES+3 cycles later.
- R9: finished and status hold until the next start, busy is 0 while finished is 1, and a start pulse while busy has no effect on the burst addresses or lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| startAddr | input | ADDR_W | First source address of the image |
| byteCount | input | LEN_W | Image length in bytes |
| fetchReq | output | 1 | One-cycle burst request to the byte source |
| fetchAddr | output | ADDR_W | Burst start address |
| fetchLen | output | clog2(CHUNK_BYTES+1) | Burst length in bytes |
| srcValid | input | 1 | Source presents a byte |
| srcData | input | 8 | Byte from the source |
| srcReady | output | 1 | Loader can take a byte this cycle |
| progB | output | 1 | Program request to the device, active low |
| initB | input | 1 | Device init/error line |
| doneIn | input | 1 | Device configuration-complete line |
| sclk | output | 1 | Serial configuration clock |
| sdata | output | 1 | Serial configuration data |
| busy | output | 1 | A load is in progress |
| finished | output | 1 | A load has ended; status is valid |
| status | output | 3 | 0 good, 1 checksum failure, 2 no done, 3 init never fell, 4 init never rose |

## Verification
The loader is driven with an image that spans two full bursts and a short tail, with one exactly one burst long, and with an empty image. These separate the burst-splitting arithmetic from the end-of-image test. The byte source stalls on a fixed cycle pattern, so the serial stream is checked bit by bit against a queue filled only when the source hands a byte over. This shows whether bytes are lost or repeated across stalls and burst boundaries. The device model then fails in each of four ways: init never falls, init never rises, init drops after streaming, and done never rises. Each failure must map to its own status code, and the settling interval must precede the verdict. A stray start during streaming and the self-loading variant complete the set.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_CRC     = 3'd1,
    ST_NODONE  = 3'd2,
    ST_TO_FALL = 3'd3,
    ST_TO_RISE = 3'd4
  } loadStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic jobLoad;
    logic chunkIssue;
    logic streamEn;
    logic timerClr;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic remZero;
    logic chunkDone;
  } dpFlags_t;

  function automatic int unsigned maxOf3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ssl_datapath.sv
module ssl_datapath
  import ssl_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 24,
  parameter int CHUNK_BYTES = 256,
  parameter int TIMER_W     = 28
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpCmd_t                             cmd,
  output dpFlags_t                           flags,
  output logic [TIMER_W-1:0]                 timerQ,
  input  logic [ADDR_W-1:0]                  startAddr,
  input  logic [LEN_W-1:0]                   byteCount,
  output logic                               fetchReq,
  output logic [ADDR_W-1:0]                  fetchAddr,
  output logic [$clog2(CHUNK_BYTES+1)-1:0]   fetchLen,
  input  logic                               srcValid,
  input  logic [7:0]                         srcData,
  output logic                               srcReady,
  output logic                               sclk,
  output logic                               sdata
);

  localparam int CLEN_W = $clog2(CHUNK_BYTES + 1);
  localparam logic [CLEN_W-1:0] CHUNK_MAX = CLEN_W'(CHUNK_BYTES);
  localparam logic [CLEN_W-1:0] CLEN_ONE  = CLEN_W'(1);
  localparam logic [3:0]        BITS_PER  = 4'd8;

  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  remQ;
  logic [CLEN_W-1:0] chunkLeftQ;
  logic [CLEN_W-1:0] nextLen;
  logic [7:0]        shiftQ;
  logic [3:0]        bitCntQ;
  logic              phaseQ;
  logic              fetchReqQ;
  logic [ADDR_W-1:0] fetchAddrQ;
  logic [CLEN_W-1:0] fetchLenQ;
  logic              canTake;
  logic              take;

  always_comb begin
    if (remQ >= LEN_W'(CHUNK_BYTES)) nextLen = CHUNK_MAX;
    else                             nextLen = CLEN_W'(remQ);
  end

  assign canTake = cmd.streamEn && (bitCntQ == 4'd0) && (chunkLeftQ != '0);
  assign take    = canTake && srcValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      remQ       <= '0;
      chunkLeftQ <= '0;
      shiftQ     <= '0;
      bitCntQ    <= '0;
      phaseQ     <= 1'b0;
      fetchReqQ  <= 1'b0;
      fetchAddrQ <= '0;
      fetchLenQ  <= '0;
    end else begin
      fetchReqQ <= 1'b0;
      if (cmd.jobLoad) begin
        addrQ      <= startAddr;
        remQ       <= byteCount;
        chunkLeftQ <= '0;
        bitCntQ    <= '0;
        phaseQ     <= 1'b0;
        shiftQ     <= '0;
      end else if (cmd.chunkIssue) begin
        fetchReqQ  <= 1'b1;
        fetchAddrQ <= addrQ;
        fetchLenQ  <= nextLen;
        addrQ      <= addrQ + ADDR_W'(nextLen);
        remQ       <= remQ - LEN_W'(nextLen);
        chunkLeftQ <= nextLen;
      end else if (take) begin
        shiftQ     <= srcData;
        bitCntQ    <= BITS_PER;
        phaseQ     <= 1'b0;
        chunkLeftQ <= chunkLeftQ - CLEN_ONE;
      end else if (bitCntQ != 4'd0) begin
        if (!phaseQ) begin
          phaseQ <= 1'b1;
        end else begin
          phaseQ  <= 1'b0;
          shiftQ  <= {shiftQ[6:0], 1'b0};
          bitCntQ <= bitCntQ - 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             timerQ <= '0;
    else if (cmd.timerClr) timerQ <= '0;
    else if (timerQ != '1) timerQ <= timerQ + TIMER_W'(1);
  end

  assign flags.remZero   = (remQ == '0);
  assign flags.chunkDone = (chunkLeftQ == '0) && (bitCntQ == 4'd0);

  assign fetchReq  = fetchReqQ;
  assign fetchAddr = fetchAddrQ;
  assign fetchLen  = fetchLenQ;
  assign srcReady  = canTake;
  assign sclk      = (bitCntQ != 4'd0) && phaseQ;
  assign sdata     = shiftQ[7];

  AST_BURST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (fetchLen != '0) && (fetchLen <= CHUNK_MAX)); // R5

  AST_BIT_HELD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(sdata)); // R4

endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
  import ssl_pkg::*;
#(
  parameter int HAS_PROG        = 1,
  parameter int SETTLE_CYCLES   = 100000,
  parameter int SELF_CFG_CYCLES = 200000000,
  parameter int TIMEOUT_CYCLES  = 10000000,
  parameter int TIMER_W         = 28
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               initB,
  input  logic               doneIn,
  input  dpFlags_t           flags,
  input  logic [TIMER_W-1:0] timerQ,
  output dpCmd_t             cmd,
  output logic               progB,
  output logic               busy,
  output logic               finished,
  output loadStatus_e        status
);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG_LOW, S_PROG_REL, S_NEXT, S_STREAM, S_SETTLE, S_SELF, S_FIN
  } loadState_e;

  localparam loadState_e FIRST_ST = (HAS_PROG != 0) ? S_PROG_LOW : S_SELF;
  localparam logic [TIMER_W-1:0] SETTLE_LAST  = TIMER_W'(SETTLE_CYCLES - 1);
  localparam logic [TIMER_W-1:0] SELF_LAST    = TIMER_W'(SELF_CFG_CYCLES - 1);
  localparam logic [TIMER_W-1:0] TIMEOUT_LAST = TIMER_W'(TIMEOUT_CYCLES - 1);

  loadState_e  stateQ, stateD;
  loadStatus_e statusQ, statusD;

  always_comb begin
    cmd     = '0;
    stateD  = stateQ;
    statusD = statusQ;
    unique case (stateQ)
      S_IDLE, S_FIN: begin
        if (start) begin
          cmd.jobLoad  = 1'b1;
          cmd.timerClr = 1'b1;
          statusD      = ST_OK;
          stateD       = FIRST_ST;
        end
      end
      S_PROG_LOW: begin
        if (!initB) begin
          cmd.timerClr = 1'b1;
          stateD       = S_PROG_REL;
        end else if (timerQ == TIMEOUT_LAST) begin
          statusD = ST_TO_FALL;
          stateD  = S_FIN;
        end
      end
      S_PROG_REL: begin
        if (initB) begin
          stateD = S_NEXT;
        end else if (timerQ == TIMEOUT_LAST) begin
          statusD = ST_TO_RISE;
          stateD  = S_FIN;
        end
      end
      S_NEXT: begin
        if (flags.remZero) begin
          cmd.timerClr = 1'b1;
          stateD       = S_SETTLE;
        end else begin
          cmd.chunkIssue = 1'b1;
          stateD         = S_STREAM;
        end
      end
      S_STREAM: begin
        cmd.streamEn = 1'b1;
        if (flags.chunkDone) stateD = S_NEXT;
      end
      S_SETTLE: begin
        if (timerQ == SETTLE_LAST) begin
          if (!initB)       statusD = ST_CRC;
          else if (!doneIn) statusD = ST_NODONE;
          else              statusD = ST_OK;
          stateD = S_FIN;
        end
      end
      S_SELF: begin
        if (timerQ == SELF_LAST) begin
          statusD = ST_OK;
          stateD  = S_FIN;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      statusQ <= ST_OK;
    end else begin
      stateQ  <= stateD;
      statusQ <= statusD;
    end
  end

  generate
    if (HAS_PROG != 0) begin : g_prog
      assign progB = (stateQ != S_PROG_LOW);
    end else begin : g_noProg
      assign progB = 1'b1;
    end
  endgenerate

  assign busy     = (stateQ != S_IDLE) && (stateQ != S_FIN);
  assign finished = (stateQ == S_FIN);
  assign status   = statusQ;

  AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progB) |-> (!$past(initB) || (status == ST_TO_FALL))); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (finished && !start) |=> (finished && $stable(status))); // R9

endmodule

// File: rtl/slave_serial_loader.sv
module slave_serial_loader
  import ssl_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int LEN_W           = 24,
  parameter int CHUNK_BYTES     = 256,
  parameter int HAS_PROG        = 1,
  parameter int SETTLE_CYCLES   = 100000,
  parameter int SELF_CFG_CYCLES = 200000000,
  parameter int TIMEOUT_CYCLES  = 10000000
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic [ADDR_W-1:0]                startAddr,
  input  logic [LEN_W-1:0]                 byteCount,
  output logic                             fetchReq,
  output logic [ADDR_W-1:0]                fetchAddr,
  output logic [$clog2(CHUNK_BYTES+1)-1:0] fetchLen,
  input  logic                             srcValid,
  input  logic [7:0]                       srcData,
  output logic                             srcReady,
  output logic                             progB,
  input  logic                             initB,
  input  logic                             doneIn,
  output logic                             sclk,
  output logic                             sdata,
  output logic                             busy,
  output logic                             finished,
  output logic [2:0]                       status
);

  localparam int unsigned LIMIT_MAX =
    maxOf3(SETTLE_CYCLES, SELF_CFG_CYCLES, TIMEOUT_CYCLES);
  localparam int TIMER_W = $clog2(LIMIT_MAX + 1);

  dpCmd_t              cmd;
  dpFlags_t            flags;
  logic [TIMER_W-1:0]  timerQ;
  loadStatus_e         statusE;

  ssl_ctrl #(
    .HAS_PROG       (HAS_PROG),
    .SETTLE_CYCLES  (SETTLE_CYCLES),
    .SELF_CFG_CYCLES(SELF_CFG_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .TIMER_W        (TIMER_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .initB   (initB),
    .doneIn  (doneIn),
    .flags   (flags),
    .timerQ  (timerQ),
    .cmd     (cmd),
    .progB   (progB),
    .busy    (busy),
    .finished(finished),
    .status  (statusE)
  );

  ssl_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .CHUNK_BYTES(CHUNK_BYTES),
    .TIMER_W    (TIMER_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .flags    (flags),
    .timerQ   (timerQ),
    .startAddr(startAddr),
    .byteCount(byteCount),
    .fetchReq (fetchReq),
    .fetchAddr(fetchAddr),
    .fetchLen (fetchLen),
    .srcValid (srcValid),
    .srcData  (srcData),
    .srcReady (srcReady),
    .sclk     (sclk),
    .sdata    (sdata)
  );

  assign status = statusE;

  AST_SERIAL_ONLY_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> (busy && progB)); // R4

  generate
    if (HAS_PROG == 0) begin : g_selfChk
      AST_SELF_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
        !fetchReq); // R8
    end
  endgenerate

endmodule

// File: tb/slave_serial_loader_tb.sv
module slave_serial_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 40;
  localparam int TIMEOUT    = 150;
  localparam int SELFCFG    = 120;
  localparam int CHUNK      = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [23:0] startAddr = '0;
  logic [23:0] byteCount = '0;
  logic        fetchReq;
  logic [23:0] fetchAddr;
  logic [8:0]  fetchLen;
  logic        srcValid = 1'b0;
  logic [7:0]  srcData = '0;
  logic        srcReady;
  logic        progB;
  logic        initB = 1'b1;
  logic        doneIn = 1'b0;
  logic        sclk, sdata, busy, finished;
  logic [2:0]  status;

  logic        startNp = 1'b0;
  logic        fetchReqNp, srcReadyNp, progBNp, sclkNp, sdataNp, busyNp, finishedNp;
  logic [23:0] fetchAddrNp;
  logic [8:0]  fetchLenNp;
  logic [2:0]  statusNp;

  slave_serial_loader #(
    .HAS_PROG(1), .SETTLE_CYCLES(SETTLE), .SELF_CFG_CYCLES(SELFCFG),
    .TIMEOUT_CYCLES(TIMEOUT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchLen(fetchLen), .srcValid(srcValid), .srcData(srcData),
    .srcReady(srcReady), .progB(progB), .initB(initB), .doneIn(doneIn),
    .sclk(sclk), .sdata(sdata), .busy(busy), .finished(finished),
    .status(status)
  );

  slave_serial_loader #(
    .HAS_PROG(0), .SETTLE_CYCLES(SETTLE), .SELF_CFG_CYCLES(SELFCFG),
    .TIMEOUT_CYCLES(TIMEOUT)
  ) dut_np_i (
    .clk(clk), .rstN(rstN), .start(startNp), .startAddr(24'h000100),
    .byteCount(24'd16), .fetchReq(fetchReqNp), .fetchAddr(fetchAddrNp),
    .fetchLen(fetchLenNp), .srcValid(1'b0), .srcData(8'h00),
    .srcReady(srcReadyNp), .progB(progBNp), .initB(1'b1), .doneIn(1'b1),
    .sclk(sclkNp), .sdata(sdataNp), .busy(busyNp), .finished(finishedNp),
    .status(statusNp)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  // bench-side models
  bit launched = 0;
  int slaveMode = 0;       // 0 good, 1 init never falls, 2 init never rises, 3 checksum, 4 no done
  int lowCnt, hiCnt;
  bit released, crcHit;
  bit expBits[$];
  int bitsGot, bitsTotal, lastBitCyc, finishCyc;
  bit prevSclk, prevFin;
  int fetchLenLog[$];
  int fetchAddrLog[$];
  int srcAddr, srcLeft;
  bit pendHs;

  function automatic logic [7:0] dataAt(int a);
    logic [23:0] av;
    av = 24'(a);
    return (av[7:0] * 8'd13) ^ av[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tickModel();
    cyc++;
    if (!rstN) return;
    // per-clock comparisons against the bench model
    chk("R9 busy", int'(busy), int'(launched && !finished));
    if (!busy) chk("R1 progB idle", int'(progB), 1);
    chk("R3 fetch before init high", int'(fetchReq && !released), 0);
    if (slaveMode == 1 && busy) chk("R2 progB held low", int'(progB), 0);
    chk("R8 progB self-load", int'(progBNp), 1);
    chk("R8 fetch self-load", int'(fetchReqNp), 0);
    // serial capture on each sclk rise
    if (sclk && !prevSclk) begin
      if (expBits.size() == 0) chk("R4 extra bit", 1, 0);
      else chk("R4 bit value", int'(sdata), int'(expBits.pop_front()));
      bitsGot++;
      lastBitCyc = cyc;
    end
    prevSclk = sclk;
    if (finished && !prevFin) finishCyc = cyc;
    prevFin = finished;
    // byte source
    if (pendHs) begin
      for (int k = 7; k >= 0; k--) expBits.push_back(srcData[k]);
      srcAddr++;
      srcLeft--;
    end
    if (fetchReq) begin
      fetchLenLog.push_back(int'(fetchLen));
      fetchAddrLog.push_back(int'(fetchAddr));
      srcAddr = int'(fetchAddr);
      srcLeft = int'(fetchLen);
    end
    srcValid = (srcLeft > 0) && ((cyc % 5) != 2);
    srcData  = dataAt(srcAddr);
    pendHs   = srcValid && srcReady;
    // device model
    if (!progB) begin
      if (slaveMode != 1) begin
        lowCnt++;
        if (lowCnt >= 3) initB = 1'b0;
      end
    end else if (!initB && !crcHit && lowCnt >= 3) begin
      if (slaveMode != 2) begin
        hiCnt++;
        if (hiCnt >= 5) begin
          initB = 1'b1;
          released = 1;
        end
      end
    end
    if (released && progB && bitsGot == bitsTotal) begin
      if (slaveMode == 3) begin
        initB = 1'b0;
        crcHit = 1;
      end else if (slaveMode != 4) begin
        doneIn = 1'b1;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    tickModel();
  endtask

  task automatic runJob(int addr, int len, int mode, int expSt, bit pokeStart, string tag);
    int n, rem, guard, holdSt;
    slaveMode = mode;
    lowCnt = 0; hiCnt = 0; released = 0; crcHit = 0;
    initB = 1'b1; doneIn = 1'b0;
    expBits.delete(); fetchLenLog.delete(); fetchAddrLog.delete();
    bitsGot = 0; lastBitCyc = 0; finishCyc = 0;
    bitsTotal = (mode == 1 || mode == 2) ? 0 : 8 * len;
    srcLeft = 0; pendHs = 0;
    startAddr = 24'(addr);
    byteCount = 24'(len);
    start = 1'b1;
    launched = 1;
    step();
    start = 1'b0;
    guard = 0;
    while (!finished && guard < 60000) begin
      step();
      guard++;
      if (pokeStart && guard == 60) begin
        chk("R9 busy before stray start", int'(busy), 1);
        startAddr = 24'(addr + 24'h4000);
        start = 1'b1;
        step();
        start = 1'b0;
        startAddr = 24'(addr);
      end
    end
    chk({tag, " finished"}, int'(finished), 1);
    chk({tag, " status"}, int'(status), expSt);
    chk("R4 bit count", bitsGot, bitsTotal);
    n = (bitsTotal == 0) ? 0 : (len + CHUNK - 1) / CHUNK;
    chk("R5 burst count", fetchLenLog.size(), n);
    rem = len;
    for (int i = 0; i < n && i < fetchLenLog.size(); i++) begin
      chk("R5 burst length", fetchLenLog[i], (rem > CHUNK) ? CHUNK : rem);
      chk("R5 burst address", fetchAddrLog[i], addr + CHUNK * i);
      rem -= CHUNK;
    end
    if (bitsTotal > 0) begin
      chk("R6 settle lower", int'((finishCyc - lastBitCyc) >= SETTLE), 1);
      chk("R6 settle upper", int'((finishCyc - lastBitCyc) <= SETTLE + 5), 1);
    end
    holdSt = int'(status);
    repeat (8) step();
    chk("R9 finished held", int'(finished), 1);
    chk("R9 status held", int'(status), holdSt);
  endtask

  initial begin
    int c;
    repeat (4) step();
    rstN = 1'b1;
    step();
    chk("R1 progB", int'(progB), 1);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 fetchReq", int'(fetchReq), 0);
    chk("R1 srcReady", int'(srcReady), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 finished", int'(finished), 0);

    runJob(24'h001F00, 600, 0, 0, 0, "R7 good load");
    runJob(24'h000120, 256, 0, 0, 0, "R5 single burst");
    runJob(24'h000040, 0,   0, 0, 0, "R5 empty image");
    runJob(24'h000300, 40,  3, 1, 0, "R6 checksum");
    runJob(24'h000500, 40,  4, 2, 0, "R7 no done");
    runJob(24'h000600, 10,  1, 3, 0, "R2 init timeout");
    runJob(24'h000700, 10,  2, 4, 0, "R3 release timeout");
    runJob(24'h002000, 300, 0, 0, 1, "R9 stray start");

    // self-loading variant
    startNp = 1'b1;
    step();
    startNp = 1'b0;
    c = 1;
    while (!finishedNp && c < 5000) begin
      step();
      c++;
    end
    chk("R8 self-load lower", int'(c >= SELFCFG), 1);
    chk("R8 self-load upper", int'(c <= SELFCFG + 3), 1);
    chk("R8 self-load status", int'(statusNp), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R9 watchdog: actual still running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched + 1);
    $finish;
  end

endmodule